// File: doc/BRIEF.md
# Glitch-Free Clock Power-Down Sequencer

This block decides, for a clock synthesizer, whether its PLL output clock and its reference clock are passed to the pins, held low, or left floating. An asynchronous active-high power-down pin is synchronized and then walks a four-state controller through an orderly shutdown. Both clocks are gated low on their own falling edges, so no pulse is ever cut short. Only after both gates report that they have stopped are the output enables dropped, and only after that are the PLL and oscillator power-down controls raised. When power-down is released, the outputs stay stopped and floating until a stabilization count in input-clock cycles has run out and the PLL reports lock.

A register bit can float the PLL output on its own while the PLL keeps running. The same gate-then-float handshake turns it off cleanly and starts it again with full pulses. A strap pin shared with the reference output is sampled once after power-on reset to select the output frequency. From then on the pin carries the reference clock, and later values seen on its input side are ignored. The controller state is reported on a status output. The pins carry no data stream, so every port is a plain control or clock signal with no handshake.

Top module: `clk_pdseq`

## Requirements
- R1: The power-down pin passes through a two-flop synchronizer. If it is raised in RUN, the state reads RUN at the first and second falling edges of `clk_in` that follow and STOPPING at the third.
- R2: Each gated clock's output enable falls only once that clock's gate has stopped. Every high phase of a gated clock is exactly one full high phase of its source clock, so no runt pulse appears.
- R3: `pll_pd` and `osc_pd` are high only in OFF. Whenever they are high, both output enables are low and both gated clocks are low.
- R4: After power-down is released from OFF with lock high, the controller stays in STABILIZING for exactly STABLE_CYCLES `clk_in` cycles and then enters RUN. Both outputs stay stopped and floating during STABILIZING.
- R5: If lock is low when the count is done, the controller stays in STABILIZING. It enters RUN on the third rising edge after lock is raised.
- R6: If power-down is raised again during STABILIZING, the controller returns to OFF. The next release restarts the full count.
- R7: With `out_en` low in RUN, the PLL output clock stops and `pll_oe` falls, while the reference clock keeps running and `pll_pd` stays low. Raising `out_en` again restarts the clock with full-width pulses.
- R8: `freq_sel` takes the value of `strap_in` at the first `clk_in` rising edge after power-on reset is released (1 selects 100 MHz, 0 selects 96 MHz). It ignores `strap_in` from then until the next reset.
- R9: Under reset and just after it, the state is STABILIZING, both output enables are low and `pll_pd` is low. The state codes on `seq_state` are RUN=0, STOPPING=1, OFF=2 and STABILIZING=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Free-running input clock; controller and reference source |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| pd_pin | input | 1 | Asynchronous active-high power-down request |
| out_en | input | 1 | Register bit enabling the PLL output clock |
| pll_clk | input | 1 | Running PLL output clock |
| pll_lock | input | 1 | PLL stable indication (asynchronous) |
| strap_in | input | 1 | Input side of the shared strap/reference pin |
| pll_gclk | output | 1 | Gated PLL output clock toward the differential driver |
| pll_oe | output | 1 | Drive enable for the differential output (0 = floating) |
| ref_gclk | output | 1 | Gated reference clock toward the shared pin |
| ref_oe | output | 1 | Drive enable for the shared pin (0 = floating) |
| pll_pd | output | 1 | PLL power-down control |
| osc_pd | output | 1 | Oscillator power-down control |
| freq_sel | output | 1 | Latched frequency strap (1 = 100 MHz, 0 = 96 MHz) |
| seq_state | output | 2 | Controller state code |

## Verification
A power-down or lock change acts on the third rising edge of `clk_in` after it is applied. The bench drives inputs on falling edges and checks the state exactly two and three falling edges later. The stabilization length is measured by counting falling edges on which the state reads STABILIZING after leaving OFF, and it must equal STABLE_CYCLES. The enable handshakes span several cycles in two clock domains, so after random stimulus the bench waits a fixed settling window before it compares the enables, the power-down controls and the pulse counts with values computed from the applied inputs. A monitor measures the width of every gated high phase as it happens.

// File: rtl/clk_pdseq_pkg.sv
`timescale 1ns/1ps
package clk_pdseq_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_OFF  = 2'd2,
    ST_STAB = 2'd3
  } seq_state_e;
  localparam int NCH = 2;   // channel 0: PLL output, channel 1: reference
endpackage

// File: rtl/clk_pdseq_sync.sv
`timescale 1ns/1ps
module clk_pdseq_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      q  <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/clk_pdseq_gate.sv
`timescale 1ns/1ps
module clk_pdseq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic run_async,
  output logic gclk,
  output logic running
);
  logic run_s;
  logic en_q;

  clk_pdseq_sync #(.W(1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(run_async), .q(run_s)
  );

  // enable moves only on the falling edge, while the source clock is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= run_s;
  end

  assign gclk    = clk & en_q;
  assign running = en_q;

  // R2: the enable flop only follows the synchronized request
  assert_gate_follows_R2: assert property (@(negedge clk) disable iff (!rst_n)
    $past(run_s) == run_s |=> en_q == $past(run_s));
endmodule

// File: rtl/clk_pdseq_fsm.sv
`timescale 1ns/1ps
module clk_pdseq_fsm
  import clk_pdseq_pkg::*;
#(
  parameter int STABLE_CYCLES = 42955
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pd_s,
  input  logic           en_s,
  input  logic           lock_s,
  input  logic [NCH-1:0] ack_raw,
  output logic [NCH-1:0] run_req,
  output logic [NCH-1:0] oe,
  output logic           pwr_dn,
  output seq_state_e     state
);
  localparam int CW = $clog2(STABLE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

  logic [NCH-1:0] ack_s;
  logic [NCH-1:0] want;
  logic [CW-1:0]  cnt;
  logic           all_idle;
  seq_state_e     nxt;

  clk_pdseq_sync #(.W(NCH)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(ack_raw), .q(ack_s)
  );

  assign want[0] = (state == ST_RUN) && en_s;
  assign want[1] = (state == ST_RUN);

  // a request may change only after the gate has acknowledged the last one
  for (genvar i = 0; i < NCH; i++) begin : g_hs
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   run_req[i] <= 1'b0;
      else if (run_req[i] == ack_s[i]) run_req[i] <= want[i];
    end
    assign oe[i] = run_req[i] | ack_s[i];

    // R2: request held steady while a change is still in flight
    assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      run_req[i] != ack_s[i] |=> run_req[i] == $past(run_req[i]));
  end

  assign all_idle = (run_req == '0) && (ack_s == '0);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RUN:  if (pd_s) nxt = ST_STOP;
      ST_STOP: if (all_idle) nxt = ST_OFF;
      ST_OFF:  if (!pd_s) nxt = ST_STAB;
      ST_STAB: begin
        if (pd_s)                       nxt = ST_OFF;
        else if (cnt == LAST && lock_s) nxt = ST_RUN;
      end
      default: nxt = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_STAB;
      cnt   <= '0;
    end else begin
      state <= nxt;
      if (state != ST_STAB)  cnt <= '0;
      else if (cnt != LAST)  cnt <= cnt + 1'b1;
    end
  end

  assign pwr_dn = (state == ST_OFF);

  // R3: power-down is never reached straight from RUN
  assert_off_after_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_OFF && $past(state) != ST_OFF |-> $past(state) != ST_RUN);

  // R4: RUN is entered only from a finished count with lock present
  assert_stab_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_RUN && $past(state) == ST_STAB |-> $past(cnt) == LAST && $past(lock_s));

  // R6: a power-down during stabilization goes back to OFF
  assert_stab_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_STAB && pd_s |=> state == ST_OFF);
endmodule

// File: rtl/clk_pdseq.sv
`timescale 1ns/1ps
module clk_pdseq
  import clk_pdseq_pkg::*;
#(
  parameter int STABLE_CYCLES = 42955
) (
  input  logic       clk_in,
  input  logic       por_n,
  input  logic       pd_pin,
  input  logic       out_en,
  input  logic       pll_clk,
  input  logic       pll_lock,
  input  logic       strap_in,
  output logic       pll_gclk,
  output logic       pll_oe,
  output logic       ref_gclk,
  output logic       ref_oe,
  output logic       pll_pd,
  output logic       osc_pd,
  output logic       freq_sel,
  output logic [1:0] seq_state
);
  logic [2:0]     ctl_s;
  logic [NCH-1:0] run_req;
  logic [NCH-1:0] ack_raw;
  logic [NCH-1:0] oe;
  logic           pwr_dn;
  logic           strap_done;
  seq_state_e     state;

  clk_pdseq_sync #(.W(3)) u_in_sync (
    .clk(clk_in), .rst_n(por_n), .d({pll_lock, out_en, pd_pin}), .q(ctl_s)
  );

  clk_pdseq_fsm #(.STABLE_CYCLES(STABLE_CYCLES)) u_fsm (
    .clk(clk_in), .rst_n(por_n), .pd_s(ctl_s[0]), .en_s(ctl_s[1]),
    .lock_s(ctl_s[2]), .ack_raw(ack_raw), .run_req(run_req), .oe(oe),
    .pwr_dn(pwr_dn), .state(state)
  );

  clk_pdseq_gate u_gate_pll (
    .clk(pll_clk), .rst_n(por_n), .run_async(run_req[0]),
    .gclk(pll_gclk), .running(ack_raw[0])
  );

  clk_pdseq_gate u_gate_ref (
    .clk(clk_in), .rst_n(por_n), .run_async(run_req[1]),
    .gclk(ref_gclk), .running(ack_raw[1])
  );

  // strap captured once, then the pin belongs to the reference output
  always_ff @(posedge clk_in or negedge por_n) begin
    if (!por_n) begin
      strap_done <= 1'b0;
      freq_sel   <= 1'b0;
    end else if (!strap_done) begin
      strap_done <= 1'b1;
      freq_sel   <= strap_in;
    end
  end

  assign pll_oe    = oe[0];
  assign ref_oe    = oe[1];
  assign pll_pd    = pwr_dn;
  assign osc_pd    = pwr_dn;
  assign seq_state = state;

  // R3: powered down implies both outputs floating
  assert_pd_floats_R3: assert property (@(posedge clk_in) disable iff (!por_n)
    pll_pd |-> !pll_oe && !ref_oe);

  // R8: strap value frozen once captured
  assert_strap_frozen_R8: assert property (@(posedge clk_in) disable iff (!por_n)
    strap_done |=> $stable(freq_sel));

  // R2: the reference pin never floats while its gate still runs
  assert_ref_oe_R2: assert property (@(posedge clk_in) disable iff (!por_n)
    ack_raw[1] && $past(ack_raw[1]) |-> ref_oe);
endmodule

// File: tb/clk_pdseq_test.sv
`timescale 1ns/1ps
module clk_pdseq_test;
  localparam realtime CLK_PERIOD = 10.0;
  localparam realtime PLL_PERIOD = 8.0;
  localparam int      STAB       = 48;
  localparam int      SETTLE     = STAB + 80;

  logic clk_in = 1'b0, pll_clk = 1'b0;
  logic por_n = 1'b0, pd_pin = 1'b0, out_en = 1'b1, pll_lock = 1'b1, strap_in = 1'b0;
  logic pll_gclk, pll_oe, ref_gclk, ref_oe, pll_pd, osc_pd, freq_sel;
  logic [1:0] seq_state;

  int checks = 0, errors = 0;
  int glitches = 0, pll_pulses = 0, ref_pulses = 0;
  bit done = 0;
  realtime t_pll, t_ref;

  always #(CLK_PERIOD/2) clk_in  = ~clk_in;
  always #(PLL_PERIOD/2) pll_clk = ~pll_clk;

  clk_pdseq #(.STABLE_CYCLES(STAB)) uut (
    .clk_in(clk_in), .por_n(por_n), .pd_pin(pd_pin), .out_en(out_en),
    .pll_clk(pll_clk), .pll_lock(pll_lock), .strap_in(strap_in),
    .pll_gclk(pll_gclk), .pll_oe(pll_oe), .ref_gclk(ref_gclk), .ref_oe(ref_oe),
    .pll_pd(pll_pd), .osc_pd(osc_pd), .freq_sel(freq_sel), .seq_state(seq_state)
  );

  // pulse-width monitors (R2)
  always @(posedge pll_gclk) begin t_pll = $realtime; pll_pulses++; end
  always @(negedge pll_gclk) if ($realtime - t_pll != PLL_PERIOD/2) glitches++;
  always @(posedge ref_gclk) begin t_ref = $realtime; ref_pulses++; end
  always @(negedge ref_gclk) if ($realtime - t_ref != CLK_PERIOD/2) glitches++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk_in);
  endtask

  function automatic int exp_pll_oe(input logic pd, input logic en);
    return (!pd && en) ? 1 : 0;
  endfunction
  function automatic int exp_state(input logic pd);
    return pd ? 2 : 0;
  endfunction

  task automatic measure_stab(output int n);
    int guard = 0;
    n = 0;
    while (seq_state != 2'd3 && guard < 1000) begin tick(1); guard++; end
    while (seq_state == 2'd3 && n < 5000) begin n++; tick(1); end
  endtask

  task automatic do_reset(input logic strap);
    por_n = 0; strap_in = strap; pd_pin = 0; out_en = 1; pll_lock = 1;
    tick(3);
    check("R9 reset state", seq_state, 3);
    check("R9 reset pll_oe", pll_oe, 0);
    check("R9 reset ref_oe", ref_oe, 0);
    check("R9 reset pll_pd", pll_pd, 0);
    #2 por_n = 1;
    tick(2);
    strap_in = ~strap;
    tick(4);
    check("R8 strap latched", freq_sel, strap);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'h5eed_1234));
    tick(2);
    do_reset(1'b1);
    tick(SETTLE);
    check("R8 strap ignored later", freq_sel, 1);
    check("R4 run after power-up", seq_state, 0);
    check("R7 pll_oe in run", pll_oe, 1);
    check("R7 ref_oe in run", ref_oe, 1);

    // R1 exact synchronizer latency
    pd_pin = 1;
    tick(2);
    check("R1 still run after 2", seq_state, 0);
    tick(1);
    check("R1 stopping after 3", seq_state, 1);
    tick(40);
    check("R3 off state", seq_state, 2);
    check("R3 pll_pd high", pll_pd, 1);
    check("R3 osc_pd high", osc_pd, 1);
    check("R3 outputs floating", pll_oe + ref_oe, 0);
    pll_pulses = 0; ref_pulses = 0;
    tick(10);
    check("R3 no pulses while off", pll_pulses + ref_pulses, 0);

    // R4 exact stabilization length
    pd_pin = 0;
    measure_stab(n);
    check("R4 stabilization cycles", n, STAB);
    check("R4 run after count", seq_state, 0);

    // R6 abort during stabilization
    pd_pin = 1; tick(40);
    pd_pin = 0;
    while (seq_state != 2'd3) tick(1);
    tick(STAB/2);
    check("R4 floating in stab", pll_oe + ref_oe, 0);
    pd_pin = 1; tick(4);
    check("R6 back to off", seq_state, 2);
    pd_pin = 0;
    measure_stab(n);
    check("R6 count restarted", n, STAB);

    // R5 lock gating
    pd_pin = 1; tick(40);
    pll_lock = 0; pd_pin = 0;
    while (seq_state != 2'd3) tick(1);
    tick(STAB + 10);
    check("R5 held without lock", seq_state, 3);
    pll_lock = 1;
    tick(2);
    check("R5 still stab 2 after lock", seq_state, 3);
    tick(1);
    check("R5 run 3 after lock", seq_state, 0);
    tick(20);

    // R7 output enable bit
    out_en = 0; tick(30);
    check("R7 pll_oe low", pll_oe, 0);
    check("R7 ref_oe stays", ref_oe, 1);
    check("R7 pll_pd low", pll_pd, 0);
    pll_pulses = 0; ref_pulses = 0; tick(10);
    check("R7 pll stopped", pll_pulses, 0);
    check("R7 ref running", ref_pulses > 0, 1);
    out_en = 1; tick(30);
    check("R7 pll_oe back", pll_oe, 1);
    pll_pulses = 0; tick(10);
    check("R7 pll restarted", pll_pulses > 0, 1);

    // random stress with hasty toggles
    for (int it = 0; it < 20; it++) begin
      logic rpd, ren;
      rpd = 1'($urandom_range(0, 1));
      ren = 1'($urandom_range(0, 1));
      pd_pin = ~rpd; out_en = ~ren;
      tick($urandom_range(0, 6));
      pd_pin = rpd; out_en = ren;
      tick(SETTLE);
      check("R1 random state", seq_state, exp_state(rpd));
      check("R7 random pll_oe", pll_oe, exp_pll_oe(rpd, ren));
      check("R3 random ref_oe", ref_oe, rpd ? 0 : 1);
      check("R3 random pll_pd", pll_pd, rpd ? 1 : 0);
      pll_pulses = 0; ref_pulses = 0; tick(10);
      check("R7 random pll pulses", pll_pulses > 0, exp_pll_oe(rpd, ren));
      check("R3 random ref pulses", ref_pulses > 0, rpd ? 0 : 1);
    end

    do_reset(1'b0);
    tick(8);
    check("R8 strap zero ignores pin", freq_sel, 0);
    check("R2 no runt pulses", glitches, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule